// File: doc/BRIEF.md
# ATA Status Poll Sequencer

This block runs on the host side of a disk channel. After software or a controller has written a command to the drive, it waits for the command to finish and reports the outcome. It reaches the drive's status bytes through a simple register-read handshake: it raises a request with a register select, and the responder answers with an acknowledge and the status byte in the same cycle.

A poll begins on a start pulse. The block first issues a fixed number of reads of the alternate status register and throws the data away. These reads stand in for the short settle time a drive needs before its busy flag can be trusted. It then reads the main status register again and again while the busy flag is set. When busy clears, it either finishes at once with a success code, or, if the advanced check was requested, takes one more status sample and reports a prioritised outcome code. A programmable cycle limit ends the busy wait with its own code if the drive never clears busy.

The result is given as a one-cycle done pulse, a three-bit code and an error flag. The code and the error flag are registered and hold their values until the next poll finishes.

Top module: `ata_poll_seq`

## Requirements
- R1: While reset is high and after it is released, done, code, err and rd_req are all 0 until a start is accepted.
- R2: After a start is accepted, the block performs exactly SETTLE_READS (default 4) reads with rd_sel = 0 (alternate status) before its first read with rd_sel = 1 (main status). The data of these settle reads has no effect on the result.
- R3: After the settle reads, main status is read once per acknowledged cycle for as long as bit 7 (busy) of the returned byte is 1. The first byte with bit 7 = 0 ends the busy wait, and no further main reads follow unless the advanced check is on.
- R4: With adv_check low at start, a poll that sees busy clear completes with code 0 and err 0, whatever the other bits of the status byte are.
- R5: With adv_check high at start, one extra main status read follows the byte that cleared busy, and only this extra byte is classified. If its bit 0 (error) is 1, the code is 2.
- R6: In the advanced check, if bit 0 of the extra byte is 0 and bit 5 (device fault) is 1, the code is 1.
- R7: In the advanced check, if bits 0 and 5 are both 0 and bit 3 (data request) is 0, the code is 3. If bit 3 is 1, the code is 0.
- R8: Poll-phase cycles are numbered from 0. If the cycle numbered timeout_lim ends without a byte with bit 7 = 0, the poll completes with code 4, and no extra sample is taken even if adv_check is high. A not-busy byte acknowledged in that same cycle wins over the timeout.
- R9: done is high for exactly one cycle per completed poll. code and err change only in the cycle done is high, and otherwise hold their values.
- R10: err is 1 exactly when the reported code is non-zero.
- R11: A start pulse that arrives while a poll is in progress is ignored: it does not add reads, start a second poll or produce a second done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a poll (ignored while one is running) |
| adv_check | input | 1 | Classify one extra status sample when busy clears; captured at start |
| timeout_lim | input | TMR_W | Index of the last poll-phase cycle before timeout |
| rd_req | output | 1 | Register read request, held until acknowledged |
| rd_sel | output | 1 | Register select: 0 = alternate status, 1 = main status |
| rd_ack | input | 1 | Read acknowledge; rd_data valid in this cycle |
| rd_data | input | 8 | Returned status byte |
| done | output | 1 | One-cycle completion pulse |
| code | output | 3 | Outcome: 0 ok, 1 fault, 2 error, 3 no data request, 4 timeout |
| err | output | 1 | Outcome code is non-zero |

## Verification
The bench builds the block with SETTLE_READS = 4 and an 8-bit timeout_lim. Its responder acknowledges every request in the same cycle, so each poll cycle carries exactly one read, and latency, read counts and the timeout boundary follow from simple arithmetic. With this setup all 256 values of the classified byte can be swept. A grid of busy lengths against limits 0 to 5 places polls on both sides of the point where a busy wait of N reads just fits the limit or just misses it.

// File: rtl/ata_poll_pkg.sv
package ata_poll_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_POLL   = 2'd2,
        PH_CHECK  = 2'd3
    } phase_t;

    // Register select encoding on the read handshake
    typedef enum logic {
        SEL_ALT  = 1'b0,
        SEL_MAIN = 1'b1
    } regsel_t;

    // Outcome codes reported on completion
    typedef enum logic [2:0] {
        OUT_OK      = 3'd0,
        OUT_FAULT   = 3'd1,
        OUT_ERROR   = 3'd2,
        OUT_NODRQ   = 3'd3,
        OUT_TIMEOUT = 3'd4
    } outcome_t;

    // Status byte bit positions
    localparam int BIT_BUSY  = 7;
    localparam int BIT_FAULT = 5;
    localparam int BIT_DRQ   = 3;
    localparam int BIT_ERR   = 0;

    // Prioritised classification of one status sample
    function automatic outcome_t classify(input logic [7:0] s);
        if (s[BIT_ERR])        return OUT_ERROR;
        else if (s[BIT_FAULT]) return OUT_FAULT;
        else if (!s[BIT_DRQ])  return OUT_NODRQ;
        else                   return OUT_OK;
    endfunction

endpackage

// File: rtl/ata_poll_reader.sv
module ata_poll_reader
    import ata_poll_pkg::*;
#(
    parameter int SETTLE_READS = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase,
    input  logic   rd_ack,
    output logic   rd_req,
    output logic   rd_sel,
    output logic   settle_done
);

    localparam int            CW   = $clog2(SETTLE_READS + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_READS - 1);
    localparam logic [CW-1:0] LIM  = CW'(SETTLE_READS);

    logic [CW-1:0] cnt;

    // Counts acknowledged settle reads; cleared outside the settle phase
    always_ff @(posedge clk) begin
        if (rst || phase != PH_SETTLE)
            cnt <= '0;
        else if (rd_ack)
            cnt <= cnt + 1'b1;
    end

    assign rd_req      = (phase != PH_IDLE);
    assign rd_sel      = (phase == PH_SETTLE) ? SEL_ALT : SEL_MAIN;
    assign settle_done = (phase == PH_SETTLE) && rd_ack && (cnt == LAST);

    // R2: settle counter never passes its bound
    p_settle_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SETTLE) |-> (cnt < LIM));

endmodule

// File: rtl/ata_poll_timer.sv
module ata_poll_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] lim,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Counts poll-phase cycles from 0; restarts whenever run drops
    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == lim);

    // R8: the elapsed count never runs past the programmed limit
    p_no_overrun_r8: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= lim));

endmodule

// File: rtl/ata_poll_seq.sv
module ata_poll_seq
    import ata_poll_pkg::*;
#(
    parameter int SETTLE_READS = 4,
    parameter int TMR_W        = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             adv_check,
    input  logic [TMR_W-1:0] timeout_lim,
    output logic             rd_req,
    output logic             rd_sel,
    input  logic             rd_ack,
    input  logic [7:0]       rd_data,
    output logic             done,
    output logic [2:0]       code,
    output logic             err
);

    localparam int            CW     = $clog2(SETTLE_READS + 1);
    localparam logic [CW-1:0] N_SETL = CW'(SETTLE_READS);

    phase_t   phase;
    logic     adv_q;
    logic     done_q;
    outcome_t code_q;
    logic     err_q;

    logic     settle_done;
    logic     expired;
    logic     fin;
    outcome_t fin_code;
    phase_t   phase_nx;

    ata_poll_reader #(.SETTLE_READS(SETTLE_READS)) u_reader (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .rd_ack      (rd_ack),
        .rd_req      (rd_req),
        .rd_sel      (rd_sel),
        .settle_done (settle_done)
    );

    ata_poll_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (phase == PH_POLL),
        .lim     (timeout_lim),
        .expired (expired)
    );

    // Next phase and completion decision
    always_comb begin
        phase_nx = phase;
        fin      = 1'b0;
        fin_code = OUT_OK;
        unique case (phase)
            PH_IDLE: begin
                if (start) phase_nx = PH_SETTLE;
            end
            PH_SETTLE: begin
                if (settle_done) phase_nx = PH_POLL;
            end
            PH_POLL: begin
                if (rd_ack && !rd_data[BIT_BUSY]) begin
                    if (adv_q) phase_nx = PH_CHECK;
                    else begin
                        fin      = 1'b1;
                        fin_code = OUT_OK;
                    end
                end else if (expired) begin
                    fin      = 1'b1;
                    fin_code = OUT_TIMEOUT;
                end
            end
            PH_CHECK: begin
                if (rd_ack) begin
                    fin      = 1'b1;
                    fin_code = classify(rd_data);
                end
            end
            default: phase_nx = PH_IDLE;
        endcase
        if (fin) phase_nx = PH_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            adv_q  <= 1'b0;
            done_q <= 1'b0;
            code_q <= OUT_OK;
            err_q  <= 1'b0;
        end else begin
            phase  <= phase_nx;
            done_q <= fin;
            if (phase == PH_IDLE && start)
                adv_q <= adv_check;
            if (fin) begin
                code_q <= fin_code;
                err_q  <= (fin_code != OUT_OK);
            end
        end
    end

    assign done = done_q;
    assign code = code_q;
    assign err  = err_q;

    // Independent tally of settle reads for checking
    logic [CW-1:0] alt_seen;
    always_ff @(posedge clk) begin
        if (rst || phase == PH_IDLE)
            alt_seen <= '0;
        else if (rd_req && rd_ack && rd_sel == SEL_ALT)
            alt_seen <= alt_seen + 1'b1;
    end

    // R2: the busy wait starts only after all settle reads were acknowledged
    p_settle_count_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_POLL && $past(phase) == PH_SETTLE) |-> (alt_seen == N_SETL));

    // R9: completion pulse lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9: code moves only together with done
    p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_q) |-> done_q);

    // R9: every poll that ends reports a completion
    p_exit_done_r9: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> (phase != PH_IDLE) || done_q);

    // R10: error flag agrees with the reported code
    p_err_flag_r10: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (err_q == (code_q != OUT_OK)));

endmodule

// File: tb/ata_poll_seq_test.sv
module ata_poll_seq_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst;
    logic       start;
    logic       adv_check;
    logic [7:0] tlim;
    logic       rd_req, rd_sel, rd_ack;
    logic [7:0] rd_data;
    logic       done;
    logic [2:0] code;
    logic       err;

    int tests = 0;
    int fails = 0;

    // Responder state
    logic       clr;
    int         alt_cnt, main_cnt, alt_at_main;
    logic       seen_main;
    int         busy_n;
    logic [7:0] clear_b, check_b;

    ata_poll_seq #(.SETTLE_READS(4), .TMR_W(8)) uut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .adv_check   (adv_check),
        .timeout_lim (tlim),
        .rd_req      (rd_req),
        .rd_sel      (rd_sel),
        .rd_ack      (rd_ack),
        .rd_data     (rd_data),
        .done        (done),
        .code        (code),
        .err         (err)
    );

    // Same-cycle acknowledge
    assign rd_ack = rd_req;

    always_comb begin
        if (!rd_sel)                 rd_data = 8'hFF;
        else if (main_cnt < busy_n)  rd_data = 8'h80 | check_b;
        else if (main_cnt == busy_n) rd_data = clear_b;
        else                         rd_data = check_b;
    end

    always @(posedge clk) begin
        if (clr) begin
            alt_cnt     <= 0;
            main_cnt    <= 0;
            alt_at_main <= -1;
            seen_main   <= 1'b0;
        end else if (rd_req) begin
            if (rd_sel) begin
                main_cnt <= main_cnt + 1;
                if (!seen_main) begin
                    seen_main   <= 1'b1;
                    alt_at_main <= alt_cnt;
                end
            end else begin
                alt_cnt <= alt_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input bit adv, input int b, input int lim,
                       input logic [7:0] cb, input logic [7:0] kb, input bit poke);
        int  lat;
        int  exp_lat, exp_code, exp_main;
        bit  to;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr       = 1'b0;
        busy_n    = b;
        clear_b   = cb;
        check_b   = kb;
        adv_check = adv;
        tlim      = 8'(lim);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 0;
        while (1) begin
            @(negedge clk);
            lat++;
            start = poke && (lat == 2 || lat == 7);
            if (done) break;
            if (lat > 300) begin
                chk("R9 poll never completed", lat, 0);
                break;
            end
        end
        start = 1'b0;

        to       = (b > lim);
        exp_lat  = to ? 5 + lim : 5 + b + (adv ? 1 : 0);
        exp_main = to ? lim + 1 : b + 1 + (adv ? 1 : 0);
        if (to)          exp_code = 4;
        else if (!adv)   exp_code = 0;
        else if (kb[0])  exp_code = 2;
        else if (kb[5])  exp_code = 1;
        else if (!kb[3]) exp_code = 3;
        else             exp_code = 0;

        chk(to ? "R8 latency" : "R3 latency", lat, exp_lat);
        if (to)          chk("R8 code", int'(code), exp_code);
        else if (!adv)   chk("R4 code", int'(code), exp_code);
        else if (kb[0])  chk("R5 code", int'(code), exp_code);
        else if (kb[5])  chk("R6 code", int'(code), exp_code);
        else             chk("R7 code", int'(code), exp_code);
        chk("R10 err", int'(err), (exp_code != 0) ? 1 : 0);
        chk("R2 settle reads before main", alt_at_main, 4);
        chk("R2 settle read total", alt_cnt, 4);
        chk("R3 main read count", main_cnt, exp_main);

        @(negedge clk);
        chk("R9 done pulse width", int'(done), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 code held", int'(code), exp_code);
            if (poke) begin
                chk("R11 no second done", int'(done), 0);
                chk("R11 no extra request", int'(rd_req), 0);
            end
        end
        if (poke) chk("R11 main reads unchanged", main_cnt, exp_main);
    endtask

    initial begin
        #(20 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        start     = 1'b0;
        adv_check = 1'b0;
        tlim      = 8'd0;
        clr       = 1'b1;
        busy_n    = 0;
        clear_b   = 8'h00;
        check_b   = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 done in reset", int'(done), 0);
        chk("R1 code in reset", int'(code), 0);
        chk("R1 err in reset", int'(err), 0);
        chk("R1 rd_req in reset", int'(rd_req), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", int'(rd_req), 0);

        // Advanced check: every value of the classified byte
        for (int v = 0; v < 256; v++)
            run(1'b1, 1, 100, 8'h00, 8'(v), 1'b0);

        // No advanced check: busy lengths and ignored flag bits
        for (int b = 0; b < 8; b++) begin
            run(1'b0, b, 100, 8'h01, 8'h21, 1'b0);
            run(1'b0, b, 100, 8'h21, 8'h00, 1'b0);
            run(1'b0, b, 100, 8'h7F, 8'h01, 1'b0);
            run(1'b0, b, 100, 8'h00, 8'h20, 1'b0);
        end

        // Timeout boundary grid
        for (int lim = 0; lim < 6; lim++)
            for (int b = 0; b < 7; b++) begin
                run(1'b0, b, lim, 8'h00, 8'h08, 1'b0);
                run(1'b1, b, lim, 8'h00, 8'h01, 1'b0);
            end

        // Start pulses while busy
        run(1'b1, 4, 100, 8'h00, 8'h20, 1'b1);
        run(1'b0, 3, 100, 8'h00, 8'h00, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule